// File: doc/BRIEF.md
# Ethernet Transmit Status Vector Generator

This block sits beside the transmit path of an Ethernet MAC. It watches the bytes of one outgoing frame, from the first destination address byte through the last check-sequence byte, and it follows the side events the MAC reports while sending: medium-busy waiting, collisions, aborts, host underrun and backpressure. When the frame ends, either by completing or by being aborted, it builds a 32-bit status word. The word is loaded into an output register with a one-cycle valid strobe and held there until the next frame ends.

The block inspects the frame header. It classifies the destination as multicast or broadcast, checks the length/type field against the payload size, recognises tagged and MAC-control frames, and picks out the pause opcode. It also times deferral in speed-dependent units using an external tick. It flags collisions that fall after the first 64 bytes of an attempt. A 16-bit byte total covers every attempt of the frame, including the attempts that collided.

Top module: `eth_txstat_gen`

## Requirements
- R1: While reset is asserted and after it is released, `status_word` reads 0 and `status_valid` is low until the first frame ends.
- R2: A byte with `frame_eof` set completes the frame. On the following clock edge `status_valid` pulses for one cycle and bit 3 (done) of the new word is 1. The word keeps its value, and the strobe stays low, until the next frame ends.
- R3: A `coll_abort` pulse ends the frame with bit 8 set and bit 3 clear. An `underrun` pulse ends the frame with bit 11 set and bit 3 clear. In both cases the word is loaded on the next edge with the strobe.
- R4: Bit 4 (multicast) copies bit 0 of the first destination byte. Bit 5 (broadcast) is set when all six destination bytes are 0xFF, and bit 4 is then also set.
- R5: Bit 2 is set when the length/type field (bytes 12 and 13, high byte first) exceeds 1500, type values included. Bit 31 is set when that field equals 0x8100.
- R6: On a completed frame, bit 1 is set when the field is 1500 or less and differs from the payload count (frame bytes minus 18). A field below 46 with a payload of exactly 46 is accepted as padding.
- R7: Bit 28 is set when the field equals 0x8808. Bit 29 is set when such a frame also carries 0x0001 in bytes 14 and 15.
- R8: Bit 6 is set when `carrier_busy` was high while no attempt was in progress since the previous word, provided the deferral was not excessive.
- R9: Bit 7 is set, and bit 6 cleared, when more than 6071 `bit_tick` pulses (`speed_fast`=1) or more than 24287 pulses (`speed_fast`=0) arrived during deferral.
- R10: Bit 9 is set when a `coll_pulse` arrives after 64 or more bytes of the current attempt have been sent.
- R11: Bits 27:12 hold the number of bytes sent over all attempts of the frame.
- R12: Bit 10 is set when that total reaches 65536. The field then reads 0xFFFF.
- R13: Bit 0 copies `fcs_bad` in the completing cycle. Bit 30 is set when `backpressure` was high at any cycle since the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A frame byte is present on `byte_data` |
| byte_data | input | 8 | Frame byte |
| frame_sof | input | 1 | Marks the first byte of an attempt |
| frame_eof | input | 1 | Marks the last byte of a completed frame |
| fcs_bad | input | 1 | Check sequence mismatch, valid with the last byte |
| carrier_busy | input | 1 | Medium busy, transmitter deferring |
| bit_tick | input | 1 | One pulse per nibble (fast) or per bit (slow) |
| speed_fast | input | 1 | 1 selects 100 Mbps deferral limit, 0 selects 10 Mbps |
| coll_pulse | input | 1 | Collision ends the current attempt |
| coll_abort | input | 1 | Collision limit reached, frame aborted |
| underrun | input | 1 | Host buffer underrun, frame aborted |
| backpressure | input | 1 | Backpressure applied |
| status_word | output | 32 | Latched transmit status |
| status_valid | output | 1 | One-cycle strobe when a new word is loaded |

## Verification
On every cycle the assertions check how the strobe and the word relate to frame completion and abort, and that the word stays unchanged between strobes. They also check the internal consistency of the flags: broadcast with multicast, pause with control, the tag value with out-of-range, a length error never alongside out-of-range, the two deferral bits never together, and a saturated count field whenever the giant bit is set. Only the bench scenarios can show that the values are right. These cover the header classification for chosen addresses and fields, the exact deferral tick limits in each speed mode, the 63/64-byte late-collision boundary, totals summed over collided attempts, the padding rule, and the 65536-byte saturation.

// File: rtl/eth_txstat_pkg.sv
package eth_txstat_pkg;
  // Status word bit positions (fixed layout decoded by software)
  localparam int SB_CRC    = 0;
  localparam int SB_LENCHK = 1;
  localparam int SB_RANGE  = 2;
  localparam int SB_DONE   = 3;
  localparam int SB_MCAST  = 4;
  localparam int SB_BCAST  = 5;
  localparam int SB_DEFER  = 6;
  localparam int SB_XDEFER = 7;
  localparam int SB_XCOLL  = 8;
  localparam int SB_LATE   = 9;
  localparam int SB_GIANT  = 10;
  localparam int SB_URUN   = 11;
  localparam int SB_CNT_LO = 12;
  localparam int SB_CTRL   = 28;
  localparam int SB_PAUSE  = 29;
  localparam int SB_BPRESS = 30;
  localparam int SB_VLAN   = 31;

  localparam logic [15:0] ET_TAGGED  = 16'h8100;
  localparam logic [15:0] ET_MACCTRL = 16'h8808;
  localparam logic [15:0] OPC_PAUSE  = 16'h0001;

  typedef struct packed {
    logic        mcast;
    logic        bcast;
    logic [15:0] lentype;
    logic [15:0] opcode;
  } hdr_info_t;
endpackage

// File: rtl/txs_hdr_parse.sv
module txs_hdr_parse
  import eth_txstat_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             frame_sof,
  input  logic             clr,
  input  logic             coll_pulse,
  output hdr_info_t        hdr,
  output logic [CNT_W-1:0] att_q,
  output logic [CNT_W-1:0] att_now,
  output logic             in_att
);
  localparam logic [CNT_W-1:0] POS_MAX = '1;
  localparam logic [CNT_W-1:0] POS_DA0 = CNT_W'(0);
  localparam logic [CNT_W-1:0] POS_DAN = CNT_W'(6);
  localparam logic [CNT_W-1:0] POS_LTH = CNT_W'(12);
  localparam logic [CNT_W-1:0] POS_LTL = CNT_W'(13);
  localparam logic [CNT_W-1:0] POS_OPH = CNT_W'(14);
  localparam logic [CNT_W-1:0] POS_OPL = CNT_W'(15);

  hdr_info_t        hdr_d, hdr_q;
  logic [CNT_W-1:0] att_d, pos_cur;
  logic             in_d, in_q;

  // position of the byte on the bus within the current attempt
  always_comb begin
    pos_cur = frame_sof ? '0 : att_q;
  end

  always_comb begin
    hdr_d = hdr_q;
    att_d = att_q;
    if (byte_valid) begin
      att_d = (pos_cur == POS_MAX) ? pos_cur : pos_cur + 1'b1;
      if (pos_cur == POS_DA0) begin
        hdr_d.mcast = byte_data[0];
        hdr_d.bcast = (byte_data == 8'hFF);
      end else if (pos_cur < POS_DAN) begin
        hdr_d.bcast = hdr_q.bcast & (byte_data == 8'hFF);
      end else if (pos_cur == POS_LTH) begin
        hdr_d.lentype[15:8] = byte_data;
      end else if (pos_cur == POS_LTL) begin
        hdr_d.lentype[7:0] = byte_data;
      end else if (pos_cur == POS_OPH) begin
        hdr_d.opcode[15:8] = byte_data;
      end else if (pos_cur == POS_OPL) begin
        hdr_d.opcode[7:0] = byte_data;
      end
    end
  end

  always_comb begin
    in_d = in_q;
    if (clr || coll_pulse) begin
      in_d = 1'b0;
    end else if (byte_valid && frame_sof) begin
      in_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      att_q <= '0;
      in_q  <= 1'b0;
    end else begin
      hdr_q <= hdr_d;
      att_q <= att_d;
      in_q  <= in_d;
    end
  end

  assign hdr     = hdr_q;
  assign att_now = byte_valid ? att_d : att_q;
  assign in_att  = in_q;
endmodule

// File: rtl/txs_defer_timer.sv
module txs_defer_timer #(
  parameter int DEFER_W  = 15,
  parameter int FAST_LIM = 6071,
  parameter int SLOW_LIM = 24287
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic carrier_busy,
  input  logic bit_tick,
  input  logic in_att,
  input  logic speed_fast,
  output logic defer_flag,
  output logic xdefer_flag
);
  localparam logic [DEFER_W-1:0] CNT_MAX  = '1;
  localparam logic [DEFER_W-1:0] LIM_FAST = DEFER_W'(FAST_LIM);
  localparam logic [DEFER_W-1:0] LIM_SLOW = DEFER_W'(SLOW_LIM);

  logic [DEFER_W-1:0] cnt_d, cnt_q, lim;
  logic               seen_d, seen_q, waiting;

  always_comb begin
    waiting = carrier_busy && !in_att;
    seen_d  = seen_q | waiting;
    cnt_d   = cnt_q;
    if (waiting && bit_tick && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (clr) begin
      seen_d = 1'b0;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  always_comb begin
    lim         = speed_fast ? LIM_FAST : LIM_SLOW;
    xdefer_flag = (cnt_q > lim);
    defer_flag  = seen_q && !xdefer_flag;
  end
endmodule

// File: rtl/txs_byte_tally.sv
module txs_byte_tally #(
  parameter int CNT_W      = 16,
  parameter int LATE_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             byte_valid,
  input  logic             coll_pulse,
  input  logic [CNT_W-1:0] att_len,
  output logic [CNT_W-1:0] total_now,
  output logic             giant_now,
  output logic             late_now
);
  localparam logic [CNT_W-1:0] LATE_C = CNT_W'(LATE_BYTES);

  logic [CNT_W:0] tot_q, tot_inc, tot_d;
  logic           late_q, late_d;

  always_comb begin
    tot_inc = tot_q;
    if (byte_valid && !tot_q[CNT_W]) begin
      tot_inc = tot_q + 1'b1;
    end
    giant_now = tot_inc[CNT_W];
    total_now = giant_now ? '1 : tot_inc[CNT_W-1:0];
    late_now  = late_q | (coll_pulse && (att_len >= LATE_C));
    tot_d     = clr ? '0 : tot_inc;
    late_d    = clr ? 1'b0 : late_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q  <= '0;
      late_q <= 1'b0;
    end else begin
      tot_q  <= tot_d;
      late_q <= late_d;
    end
  end
endmodule

// File: rtl/eth_txstat_gen.sv
module eth_txstat_gen
  import eth_txstat_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DEFER_W    = 15,
  parameter int FAST_LIM   = 6071,
  parameter int SLOW_LIM   = 24287,
  parameter int LATE_BYTES = 64,
  parameter int MAX_LEN    = 1500,
  parameter int MIN_PAY    = 46,
  parameter int OVERHEAD   = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  input  logic        frame_sof,
  input  logic        frame_eof,
  input  logic        fcs_bad,
  input  logic        carrier_busy,
  input  logic        bit_tick,
  input  logic        speed_fast,
  input  logic        coll_pulse,
  input  logic        coll_abort,
  input  logic        underrun,
  input  logic        backpressure,
  output logic [31:0] status_word,
  output logic        status_valid
);
  localparam logic [15:0] MAXLEN16 = 16'(MAX_LEN);
  localparam logic [15:0] MINPAY16 = 16'(MIN_PAY);
  localparam logic [31:0] OVH32    = 32'(OVERHEAD);
  localparam logic [31:0] MINPAY32 = 32'(MIN_PAY);

  hdr_info_t        hdr;
  logic [CNT_W-1:0] att_q, att_now, total_now;
  logic             in_att, defer_flag, xdefer_flag, giant_now, late_now;
  logic             eof_evt, abort_evt, finish, ok;
  logic             is_len, len_err, bp_d, bp_q;
  logic [31:0]      len32, pay32, lt32;
  logic [31:0]      word_d, word_q;
  logic             valid_q;

  always_comb begin
    eof_evt   = byte_valid && frame_eof;
    abort_evt = coll_abort || underrun;
    finish    = eof_evt || abort_evt;
    ok        = eof_evt && !abort_evt;
  end

  txs_hdr_parse #(.CNT_W(CNT_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .frame_sof(frame_sof), .clr(finish), .coll_pulse(coll_pulse),
    .hdr(hdr), .att_q(att_q), .att_now(att_now), .in_att(in_att)
  );

  txs_defer_timer #(.DEFER_W(DEFER_W), .FAST_LIM(FAST_LIM), .SLOW_LIM(SLOW_LIM)) u_defer (
    .clk(clk), .rst_n(rst_n), .clr(finish), .carrier_busy(carrier_busy),
    .bit_tick(bit_tick), .in_att(in_att), .speed_fast(speed_fast),
    .defer_flag(defer_flag), .xdefer_flag(xdefer_flag)
  );

  txs_byte_tally #(.CNT_W(CNT_W), .LATE_BYTES(LATE_BYTES)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(finish), .byte_valid(byte_valid),
    .coll_pulse(coll_pulse), .att_len(att_q),
    .total_now(total_now), .giant_now(giant_now), .late_now(late_now)
  );

  // length field versus payload actually sent in the completing attempt
  always_comb begin
    is_len  = (hdr.lentype <= MAXLEN16);
    len32   = 32'(att_now);
    pay32   = len32 - OVH32;
    lt32    = 32'(hdr.lentype);
    len_err = 1'b0;
    if (is_len) begin
      if (len32 < OVH32) begin
        len_err = 1'b1;
      end else begin
        len_err = !((pay32 == lt32) ||
                    ((hdr.lentype < MINPAY16) && (pay32 == MINPAY32)));
      end
    end
  end

  always_comb begin
    bp_d = finish ? 1'b0 : (bp_q | backpressure);
  end

  always_comb begin
    word_d             = '0;
    word_d[SB_CRC]     = ok && fcs_bad;
    word_d[SB_LENCHK]  = ok && len_err;
    word_d[SB_RANGE]   = !is_len;
    word_d[SB_DONE]    = ok;
    word_d[SB_MCAST]   = hdr.mcast;
    word_d[SB_BCAST]   = hdr.bcast;
    word_d[SB_DEFER]   = defer_flag;
    word_d[SB_XDEFER]  = xdefer_flag;
    word_d[SB_XCOLL]   = coll_abort;
    word_d[SB_LATE]    = late_now;
    word_d[SB_GIANT]   = giant_now;
    word_d[SB_URUN]    = underrun;
    word_d[SB_CNT_LO +: 16] = 16'(total_now);
    word_d[SB_CTRL]    = (hdr.lentype == ET_MACCTRL);
    word_d[SB_PAUSE]   = (hdr.lentype == ET_MACCTRL) && (hdr.opcode == OPC_PAUSE);
    word_d[SB_BPRESS]  = bp_q | backpressure;
    word_d[SB_VLAN]    = (hdr.lentype == ET_TAGGED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      bp_q    <= 1'b0;
    end else begin
      if (finish) begin
        word_q <= word_d;
      end
      valid_q <= finish;
      bp_q    <= bp_d;
    end
  end

  assign status_word  = word_q;
  assign status_valid = valid_q;
endmodule

// File: rtl/eth_txstat_chk.sv
module eth_txstat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_valid,
  input logic        frame_eof,
  input logic        coll_abort,
  input logic        underrun,
  input logic [31:0] status_word,
  input logic        status_valid
);
  // R2
  finish_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && frame_eof) |=> status_valid);

  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_valid |-> $stable(status_word));

  // R3
  abort_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_abort || underrun) |=> (status_valid && !status_word[3]));

  // R4
  bcast_mcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[5] |-> status_word[4]);

  // R5
  tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[31] |-> status_word[2]);

  // R6
  lenchk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[1] |-> !status_word[2]);

  // R7
  pause_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[29] |-> (status_word[28] && status_word[2]));

  // R9
  defer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_word[6] && status_word[7]));

  // R12
  giant_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[10] |-> (status_word[27:12] == 16'hFFFF));
endmodule

bind eth_txstat_gen eth_txstat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .frame_eof(frame_eof),
  .coll_abort(coll_abort), .underrun(underrun),
  .status_word(status_word), .status_valid(status_valid)
);

// File: tb/test_eth_txstat_gen.sv
module test_eth_txstat_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        frame_sof = 1'b0, frame_eof = 1'b0, fcs_bad = 1'b0;
  logic        carrier_busy = 1'b0, bit_tick = 1'b0, speed_fast = 1'b1;
  logic        coll_pulse = 1'b0, coll_abort = 1'b0, underrun = 1'b0, backpressure = 1'b0;
  logic [31:0] status_word;
  logic        status_valid;
  int          n_tests = 0;
  int          n_fail = 0;

  localparam logic [31:0] CRC = 32'h1 << 0,  LEN = 32'h1 << 1,  RNG = 32'h1 << 2;
  localparam logic [31:0] DN  = 32'h1 << 3,  MC  = 32'h1 << 4,  BC  = 32'h1 << 5;
  localparam logic [31:0] DF  = 32'h1 << 6,  XDF = 32'h1 << 7,  XCL = 32'h1 << 8;
  localparam logic [31:0] LT  = 32'h1 << 9,  GI  = 32'h1 << 10, UR  = 32'h1 << 11;
  localparam logic [31:0] CT  = 32'h1 << 28, PS  = 32'h1 << 29, BP  = 32'h1 << 30;
  localparam logic [31:0] VL  = 32'h1 << 31;
  localparam logic [47:0] DA_UNI = 48'h00_11_22_33_44_55;

  always #2 clk = ~clk;

  eth_txstat_gen i_eth_txstat_gen (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .frame_sof(frame_sof), .frame_eof(frame_eof), .fcs_bad(fcs_bad),
    .carrier_busy(carrier_busy), .bit_tick(bit_tick), .speed_fast(speed_fast),
    .coll_pulse(coll_pulse), .coll_abort(coll_abort), .underrun(underrun),
    .backpressure(backpressure), .status_word(status_word), .status_valid(status_valid)
  );

  function automatic logic [31:0] cw(int n);
    return 32'(n) << 12;
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // one attempt of tot bytes; ends at a negedge with bus idle
  task automatic send_attempt(logic [47:0] da, logic [15:0] lt, logic [15:0] op,
                              int tot, bit last, bit crc);
    for (int i = 0; i < tot; i++) begin
      logic [7:0] b;
      if (i < 6)             b = da[47-8*i -: 8];
      else if (i < 12)       b = 8'h10 + 8'(i);
      else if (i == 12)      b = lt[15:8];
      else if (i == 13)      b = lt[7:0];
      else if (i == 14)      b = op[15:8];
      else if (i == 15)      b = op[7:0];
      else if (i >= tot - 4) b = 8'hA5;
      else                   b = 8'(i);
      @(negedge clk);
      byte_valid = 1'b1;
      byte_data  = b;
      frame_sof  = (i == 0);
      frame_eof  = last && (i == tot - 1);
      fcs_bad    = crc && (i == tot - 1);
    end
    @(negedge clk);
    byte_valid = 1'b0; frame_sof = 1'b0; frame_eof = 1'b0; fcs_bad = 1'b0;
  endtask

  task automatic frame_chk(string rq, logic [47:0] da, logic [15:0] lt,
                           logic [15:0] op, int tot, bit crc, logic [31:0] exp);
    send_attempt(da, lt, op, tot, 1'b1, crc);
    chk({rq, " strobe"}, {31'b0, status_valid}, 32'h1);
    chk(rq, status_word, exp);
  endtask

  task automatic defer_wait(int n, bit fast);
    speed_fast   = fast;
    carrier_busy = 1'b1;
    bit_tick     = 1'b1;
    repeat (n) @(negedge clk);
    carrier_busy = 1'b0;
    bit_tick     = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 word in reset", status_word, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word after reset", status_word, 32'h0);
    chk("R1 strobe after reset", {31'b0, status_valid}, 32'h0);
  endtask

  task automatic t_basic;
    frame_chk("R2 R11 unicast", DA_UNI, 16'd46, 16'h0, 64, 1'b0, cw(64) | DN);
    repeat (3) @(negedge clk);
    chk("R2 strobe drops", {31'b0, status_valid}, 32'h0);
    chk("R2 word held", status_word, cw(64) | DN);
  endtask

  task automatic t_addr;
    frame_chk("R4 R5 multicast type", 48'h01_00_5E_00_00_01, 16'h0800, 16'h0, 68, 1'b0,
              cw(68) | DN | MC | RNG);
    frame_chk("R4 R5 broadcast", 48'hFF_FF_FF_FF_FF_FF, 16'h0806, 16'h0, 64, 1'b0,
              cw(64) | DN | MC | BC | RNG);
    frame_chk("R4 near broadcast", 48'hFF_FF_FF_FF_FF_FE, 16'd46, 16'h0, 64, 1'b0,
              cw(64) | DN | MC);
    frame_chk("R5 tagged", DA_UNI, 16'h8100, 16'h0, 64, 1'b0, cw(64) | DN | RNG | VL);
    frame_chk("R5 just above 1500", DA_UNI, 16'd1501, 16'h0, 64, 1'b0, cw(64) | DN | RNG);
  endtask

  task automatic t_len;
    frame_chk("R6 mismatch", DA_UNI, 16'd100, 16'h0, 78, 1'b0, cw(78) | DN | LEN);
    frame_chk("R6 padded", DA_UNI, 16'd10, 16'h0, 64, 1'b0, cw(64) | DN);
    frame_chk("R6 exact", DA_UNI, 16'd200, 16'h0, 218, 1'b0, cw(218) | DN);
    frame_chk("R6 1500 short", DA_UNI, 16'd1500, 16'h0, 64, 1'b0, cw(64) | DN | LEN);
  endtask

  task automatic t_ctrl;
    frame_chk("R7 pause", 48'h01_80_C2_00_00_01, 16'h8808, 16'h0001, 64, 1'b0,
              cw(64) | DN | MC | RNG | CT | PS);
    frame_chk("R7 other opcode", 48'h01_80_C2_00_00_01, 16'h8808, 16'h0002, 64, 1'b0,
              cw(64) | DN | MC | RNG | CT);
  endtask

  task automatic t_misc;
    @(negedge clk); backpressure = 1'b1;
    @(negedge clk); backpressure = 1'b0;
    frame_chk("R13 crc and bp", DA_UNI, 16'd46, 16'h0, 64, 1'b1, cw(64) | DN | CRC | BP);
    frame_chk("R13 bp cleared", DA_UNI, 16'd46, 16'h0, 64, 1'b0, cw(64) | DN);
  endtask

  task automatic t_defer;
    defer_wait(100, 1'b1);
    frame_chk("R8 short defer", DA_UNI, 16'd46, 16'h0, 64, 1'b0, cw(64) | DN | DF);
    defer_wait(6071, 1'b1);
    frame_chk("R8 at fast limit", DA_UNI, 16'd46, 16'h0, 64, 1'b0, cw(64) | DN | DF);
    defer_wait(6072, 1'b1);
    frame_chk("R9 over fast limit", DA_UNI, 16'd46, 16'h0, 64, 1'b0, cw(64) | DN | XDF);
    defer_wait(6072, 1'b0);
    frame_chk("R9 slow under", DA_UNI, 16'd46, 16'h0, 64, 1'b0, cw(64) | DN | DF);
    defer_wait(24288, 1'b0);
    frame_chk("R9 over slow limit", DA_UNI, 16'd46, 16'h0, 64, 1'b0, cw(64) | DN | XDF);
    speed_fast = 1'b1;
  endtask

  task automatic t_coll;
    send_attempt(DA_UNI, 16'd46, 16'h0, 63, 1'b0, 1'b0);
    coll_pulse = 1'b1; @(negedge clk); coll_pulse = 1'b0;
    frame_chk("R10 R11 early coll", DA_UNI, 16'd46, 16'h0, 64, 1'b0, cw(127) | DN);
    send_attempt(DA_UNI, 16'd46, 16'h0, 64, 1'b0, 1'b0);
    coll_pulse = 1'b1; @(negedge clk); coll_pulse = 1'b0;
    frame_chk("R10 R11 late coll", DA_UNI, 16'd46, 16'h0, 64, 1'b0, cw(128) | DN | LT);
  endtask

  task automatic t_abort;
    send_attempt(DA_UNI, 16'd46, 16'h0, 20, 1'b0, 1'b0);
    coll_abort = 1'b1; @(negedge clk); coll_abort = 1'b0;
    chk("R3 abort strobe", {31'b0, status_valid}, 32'h1);
    chk("R3 coll abort", status_word, cw(20) | XCL);
    send_attempt(DA_UNI, 16'd46, 16'h0, 16, 1'b0, 1'b0);
    underrun = 1'b1; @(negedge clk); underrun = 1'b0;
    chk("R3 underrun", status_word, cw(16) | UR);
  endtask

  task automatic t_giant;
    frame_chk("R12 giant", DA_UNI, 16'h0800, 16'h0, 65536, 1'b0,
              cw(16'hFFFF) | DN | RNG | GI);
    frame_chk("R12 cleared", DA_UNI, 16'd46, 16'h0, 64, 1'b0, cw(64) | DN);
  endtask

  task automatic run_all;
    t_reset();
    t_basic();
    t_addr();
    t_len();
    t_ctrl();
    t_misc();
    t_defer();
    t_coll();
    t_abort();
    t_giant();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule